// File: doc/BRIEF.md
# USB Device Endpoint Handshake Responder

This block holds the control state of every device endpoint, for both transfer directions, and decides how the device answers each host token. For each token it takes the direction, the endpoint number, whether the endpoint FIFO can take or give a packet, and whether the CRC of the received data was good. It also takes the PID of the received data packet and the parity of the current frame. One cycle later it gives a response code. It also tells the data path whether an OUT packet should be kept. For IN data it gives the transmit FIFO number and the maximum packet size of that endpoint.

Software or a sequencer programs each endpoint through a single write port. A write sets the enable, activation, transfer type, STALL, forced NAK, data toggle, frame parity, CRC snoop, FIFO number and packet size. The block maintains the DATA0/DATA1 toggle itself. An OUT toggle advances when a packet is accepted. An IN toggle advances when the host acknowledges data that was sent. Isochronous endpoints use frame parity instead of the toggle.

Top module: `usb_ep_responder`

## Requirements
- R1: A token to an endpoint whose enable or activation bit is 0 gets response code NONE (0) with keep low, and changes no toggle.
- R2: On an active non-isochronous endpoint with STALL set, every token gets STALL (3), whatever the FIFO state or the forced NAK bit. For OUT, the received CRC must also pass.
- R3: With forced NAK set and STALL clear, an active non-isochronous endpoint answers NAK (2) even when its FIFO is ready.
- R4: With STALL and forced NAK clear, a non-ready FIFO gives NAK (2) and keep low.
- R5: A good OUT packet on a bulk or interrupt endpoint whose PID matches the toggle is answered ACK (1) with keep high, and the toggle inverts. The PID input is 1 for DATA1 and 0 for DATA0.
- R6: A good OUT packet whose PID does not match the toggle is answered ACK with keep low, and the toggle stays.
- R7: An OUT packet with a bad CRC gets NONE with keep low, unless snoop is set. With snoop set, the bad CRC is treated as good.
- R8: A ready IN bulk or interrupt endpoint sends DATA0 (4) or DATA1 (5) from its toggle, together with its FIFO number and packet size. The toggle inverts only on a host acknowledge for that endpoint after data was sent, so a retry repeats the same PID.
- R9: Transfer type 01 is isochronous. It never gets ACK, NAK or STALL, and it never changes the toggle. OUT data is kept only when the frame parity matches and the FIFO is ready. IN sends DATA0 only on matching parity with the FIFO ready and neither STALL nor NAK set; otherwise it gets NONE.
- R10: The response is registered. resp_valid is high exactly in the cycle after tok_valid. When no token is present the code is NONE. After reset all outputs are 0.
- R11: A configuration write loads the endpoint toggle. It takes priority over a toggle update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir_in | input | 1 | Written endpoint is IN (1) or OUT (0) |
| cfg_ep | input | EP_W | Written endpoint number |
| cfg_enable | input | 1 | Endpoint enable |
| cfg_active | input | 1 | Active in current configuration |
| cfg_type | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| cfg_stall | input | 1 | Answer all tokens with STALL |
| cfg_nak | input | 1 | Forced NAK |
| cfg_toggle | input | 1 | Data toggle value to load |
| cfg_odd | input | 1 | Isochronous frame parity (1 = odd) |
| cfg_snoop | input | 1 | Ignore CRC errors (OUT) |
| cfg_fifo | input | FIFO_W | Transmit FIFO number |
| cfg_maxpkt | input | MPS_W | Maximum packet size |
| tok_valid | input | 1 | Token strobe |
| tok_dir_in | input | 1 | Token is IN (1) or OUT (0) |
| tok_ep | input | EP_W | Token endpoint |
| fifo_ready | input | 1 | FIFO can take or supply a packet |
| crc_ok | input | 1 | Received data CRC good |
| rx_pid1 | input | 1 | Received data PID is DATA1 |
| frame_odd | input | 1 | Current frame number is odd |
| host_ack | input | 1 | Host acknowledged IN data |
| host_ack_ep | input | EP_W | Endpoint of the host acknowledge |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 3 | 0 NONE, 1 ACK, 2 NAK, 3 STALL, 4 DATA0, 5 DATA1 |
| resp_keep | output | 1 | Keep received OUT data |
| resp_fifo | output | FIFO_W | FIFO number of the addressed endpoint |
| resp_maxpkt | output | MPS_W | Packet size of the addressed endpoint |

## Verification
A wrong toggle is not seen at the moment it goes wrong. It shows at the next token to that endpoint: an IN endpoint sends the wrong DATA PID, and an OUT endpoint drops a packet it should keep or keeps one it should drop. A stale pending flag shows only after a host acknowledge, because the following IN token then repeats or skips a PID. The tests therefore run toggle sequences of several tokens and check after each response, which comes one cycle after its token.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA0 = 3'd4,
    RSP_DATA1 = 3'd5
  } resp_e;

  localparam logic [1:0] XT_ISO = 2'b01;

  typedef struct packed {
    logic       enable;
    logic       active;
    logic [1:0] xtype;
    logic       stall;
    logic       nak;
    logic       odd;
    logic       snoop;
  } ep_flags_t;

  function automatic logic ep_live(ep_flags_t f);
    return f.enable & f.active;
  endfunction

  function automatic logic crc_pass(ep_flags_t f, logic crc_ok);
    return crc_ok | f.snoop;
  endfunction

  // Priority: dead endpoint, isochronous path, CRC, STALL, forced NAK, FIFO, success.
  function automatic resp_e hs_code(logic dir_in, ep_flags_t f, logic tog,
                                    logic fifo_rdy, logic crc_ok, logic frame_odd);
    resp_e r;
    if (!ep_live(f))
      r = RSP_NONE;
    else if (f.xtype == XT_ISO)
      r = (dir_in && !f.stall && !f.nak && fifo_rdy && (frame_odd == f.odd))
          ? RSP_DATA0 : RSP_NONE;
    else if (!dir_in && !crc_pass(f, crc_ok))
      r = RSP_NONE;
    else if (f.stall)
      r = RSP_STALL;
    else if (f.nak || !fifo_rdy)
      r = RSP_NAK;
    else if (dir_in)
      r = tog ? RSP_DATA1 : RSP_DATA0;
    else
      r = RSP_ACK;
    return r;
  endfunction

  function automatic logic hs_keep(logic dir_in, ep_flags_t f, logic tog, logic fifo_rdy,
                                   logic crc_ok, logic frame_odd, logic pid1);
    logic base;
    base = !dir_in && ep_live(f) && crc_pass(f, crc_ok) && !f.stall && !f.nak && fifo_rdy;
    if (f.xtype == XT_ISO)
      return base && (frame_odd == f.odd);
    return base && (pid1 == tog);
  endfunction

endpackage

// File: rtl/usb_ep_bank.sv
module usb_ep_bank
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2,
  parameter int FIFO_W = 3,
  parameter int MPS_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EP_W-1:0]   wr_ep,
  input  ep_flags_t         wr_flags,
  input  logic              wr_tog,
  input  logic [FIFO_W-1:0] wr_fifo,
  input  logic [MPS_W-1:0]  wr_mps,
  input  logic              flip_en,
  input  logic [EP_W-1:0]   flip_ep,
  input  logic [EP_W-1:0]   rd_ep,
  output ep_flags_t         rd_flags,
  output logic              rd_tog,
  output logic [FIFO_W-1:0] rd_fifo,
  output logic [MPS_W-1:0]  rd_mps
);

  ep_flags_t         flags_q [NUM_EP];
  logic              tog_q   [NUM_EP];
  logic [FIFO_W-1:0] fifo_q  [NUM_EP];
  logic [MPS_W-1:0]  mps_q   [NUM_EP];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[e] <= '0;
        tog_q[e]   <= 1'b0;
        fifo_q[e]  <= '0;
        mps_q[e]   <= '0;
      end else if (wr_en && wr_ep == EP_W'(e)) begin
        flags_q[e] <= wr_flags;
        tog_q[e]   <= wr_tog;
        fifo_q[e]  <= wr_fifo;
        mps_q[e]   <= wr_mps;
      end else if (flip_en && flip_ep == EP_W'(e)) begin
        tog_q[e]   <= ~tog_q[e];
      end
    end
  end

  assign rd_flags = flags_q[rd_ep];
  assign rd_tog   = tog_q[rd_ep];
  assign rd_fifo  = fifo_q[rd_ep];
  assign rd_mps   = mps_q[rd_ep];

endmodule

// File: rtl/usb_ep_decide.sv
module usb_ep_decide
  import usb_ep_pkg::*;
(
  input  logic      dir_in,
  input  ep_flags_t flags,
  input  logic      tog,
  input  logic      fifo_rdy,
  input  logic      crc_ok,
  input  logic      frame_odd,
  input  logic      pid1,
  output resp_e     code,
  output logic      keep,
  output logic      out_adv,
  output logic      in_sent
);

  logic iso;

  assign iso     = (flags.xtype == XT_ISO);
  assign code    = hs_code(dir_in, flags, tog, fifo_rdy, crc_ok, frame_odd);
  assign keep    = hs_keep(dir_in, flags, tog, fifo_rdy, crc_ok, frame_odd, pid1);
  assign out_adv = keep && !iso;
  assign in_sent = dir_in && !iso && (code == RSP_DATA0 || code == RSP_DATA1);

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = $clog2(NUM_EP),
  parameter int FIFO_W = 3,
  parameter int MPS_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_dir_in,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              cfg_enable,
  input  logic              cfg_active,
  input  logic [1:0]        cfg_type,
  input  logic              cfg_stall,
  input  logic              cfg_nak,
  input  logic              cfg_toggle,
  input  logic              cfg_odd,
  input  logic              cfg_snoop,
  input  logic [FIFO_W-1:0] cfg_fifo,
  input  logic [MPS_W-1:0]  cfg_maxpkt,
  input  logic              tok_valid,
  input  logic              tok_dir_in,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              fifo_ready,
  input  logic              crc_ok,
  input  logic              rx_pid1,
  input  logic              frame_odd,
  input  logic              host_ack,
  input  logic [EP_W-1:0]   host_ack_ep,
  output logic              resp_valid,
  output logic [2:0]        resp_code,
  output logic              resp_keep,
  output logic [FIFO_W-1:0] resp_fifo,
  output logic [MPS_W-1:0]  resp_maxpkt
);

  ep_flags_t         wr_flags, in_flags, out_flags, sel_flags;
  logic              in_tog, out_tog, sel_tog;
  logic [FIFO_W-1:0] in_fifo, out_fifo;
  logic [MPS_W-1:0]  in_mps, out_mps;
  logic [NUM_EP-1:0] pend_q;
  resp_e             dec_code, resp_q;
  logic              dec_keep, dec_out_adv, dec_in_sent;

  // Named events for the checker.
  logic sel_live, sel_iso, sel_stall, sel_snoop, out_flip_ev, in_flip_ev, in_send_ev;

  assign wr_flags = '{enable: cfg_enable, active: cfg_active, xtype: cfg_type,
                      stall: cfg_stall, nak: cfg_nak, odd: cfg_odd, snoop: cfg_snoop};

  assign sel_flags   = tok_dir_in ? in_flags : out_flags;
  assign sel_tog     = tok_dir_in ? in_tog   : out_tog;
  assign sel_live    = sel_flags.enable & sel_flags.active;
  assign sel_iso     = (sel_flags.xtype == XT_ISO);
  assign sel_stall   = sel_flags.stall;
  assign sel_snoop   = sel_flags.snoop;
  assign out_flip_ev = tok_valid && !tok_dir_in && dec_out_adv;
  assign in_flip_ev  = host_ack && pend_q[host_ack_ep];
  assign in_send_ev  = tok_valid && dec_in_sent;

  usb_ep_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W), .FIFO_W(FIFO_W), .MPS_W(MPS_W)) u_in_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && cfg_dir_in), .wr_ep(cfg_ep), .wr_flags(wr_flags), .wr_tog(cfg_toggle),
    .wr_fifo(cfg_fifo), .wr_mps(cfg_maxpkt),
    .flip_en(in_flip_ev), .flip_ep(host_ack_ep),
    .rd_ep(tok_ep), .rd_flags(in_flags), .rd_tog(in_tog), .rd_fifo(in_fifo), .rd_mps(in_mps)
  );

  usb_ep_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W), .FIFO_W(FIFO_W), .MPS_W(MPS_W)) u_out_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && !cfg_dir_in), .wr_ep(cfg_ep), .wr_flags(wr_flags), .wr_tog(cfg_toggle),
    .wr_fifo(cfg_fifo), .wr_mps(cfg_maxpkt),
    .flip_en(out_flip_ev), .flip_ep(tok_ep),
    .rd_ep(tok_ep), .rd_flags(out_flags), .rd_tog(out_tog), .rd_fifo(out_fifo), .rd_mps(out_mps)
  );

  usb_ep_decide u_decide (
    .dir_in(tok_dir_in), .flags(sel_flags), .tog(sel_tog), .fifo_rdy(fifo_ready),
    .crc_ok(crc_ok), .frame_odd(frame_odd), .pid1(rx_pid1),
    .code(dec_code), .keep(dec_keep), .out_adv(dec_out_adv), .in_sent(dec_in_sent)
  );

  // An IN endpoint waits for the host acknowledge of the data it sent.
  for (genvar e = 0; e < NUM_EP; e++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_q[e] <= 1'b0;
      else if (cfg_we && cfg_dir_in && cfg_ep == EP_W'(e))
        pend_q[e] <= 1'b0;
      else if (in_send_ev && tok_ep == EP_W'(e))
        pend_q[e] <= 1'b1;
      else if (in_flip_ev && host_ack_ep == EP_W'(e))
        pend_q[e] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_q      <= RSP_NONE;
      resp_keep   <= 1'b0;
      resp_fifo   <= '0;
      resp_maxpkt <= '0;
    end else begin
      resp_valid  <= tok_valid;
      resp_q      <= tok_valid ? dec_code : RSP_NONE;
      resp_keep   <= tok_valid && dec_keep;
      resp_fifo   <= tok_valid ? (tok_dir_in ? in_fifo : out_fifo) : '0;
      resp_maxpkt <= tok_valid ? (tok_dir_in ? in_mps : out_mps) : '0;
    end
  end

  assign resp_code = resp_q;

endmodule

// File: rtl/usb_ep_responder_chk.sv
module usb_ep_responder_chk
  import usb_ep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tok_valid,
  input logic       tok_dir_in,
  input logic       crc_ok,
  input logic       resp_valid,
  input logic [2:0] resp_code,
  input logic       resp_keep,
  input logic       sel_live,
  input logic       sel_iso,
  input logic       sel_stall,
  input logic       sel_snoop,
  input logic       out_flip_ev
);

  assert_resp_follows_tok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> resp_valid);

  assert_resp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> (!resp_valid && resp_code == RSP_NONE && !resp_keep));

  assert_dead_ep_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !sel_live) |=> (resp_code == RSP_NONE && !resp_keep));

  assert_stall_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && sel_live && !sel_iso && sel_stall && (tok_dir_in || crc_ok || sel_snoop))
    |=> resp_code == RSP_STALL);

  assert_iso_no_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && sel_live && sel_iso) |=> (resp_code == RSP_NONE || resp_code == RSP_DATA0));

  assert_in_never_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_dir_in) |=> !resp_keep);

  assert_advance_means_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_flip_ev |=> (resp_keep && resp_code == RSP_ACK));

endmodule

bind usb_ep_responder usb_ep_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_dir_in(tok_dir_in), .crc_ok(crc_ok),
  .resp_valid(resp_valid), .resp_code(resp_code), .resp_keep(resp_keep),
  .sel_live(sel_live), .sel_iso(sel_iso), .sel_stall(sel_stall), .sel_snoop(sel_snoop),
  .out_flip_ev(out_flip_ev)
);

// File: tb/sim_usb_ep_responder.sv
module sim_usb_ep_responder;

  localparam int NUM_EP = 4;
  localparam int EP_W   = 2;
  localparam int FIFO_W = 3;
  localparam int MPS_W  = 11;

  localparam logic [1:0] T_ISO = 2'b01, T_BULK = 2'b10, T_INTR = 2'b11;
  localparam logic [2:0] C_NONE = 3'd0, C_ACK = 3'd1, C_NAK = 3'd2, C_STALL = 3'd3,
                         C_D0 = 3'd4, C_D1 = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_dir_in = 0, cfg_enable = 0, cfg_active = 0, cfg_stall = 0;
  logic cfg_nak = 0, cfg_toggle = 0, cfg_odd = 0, cfg_snoop = 0;
  logic [EP_W-1:0] cfg_ep = '0, tok_ep = '0, host_ack_ep = '0;
  logic [1:0] cfg_type = '0;
  logic [FIFO_W-1:0] cfg_fifo = '0;
  logic [MPS_W-1:0] cfg_maxpkt = '0;
  logic tok_valid = 0, tok_dir_in = 0, fifo_ready = 0, crc_ok = 0, rx_pid1 = 0, frame_odd = 0;
  logic host_ack = 0;
  logic resp_valid, resp_keep;
  logic [2:0] resp_code;
  logic [FIFO_W-1:0] resp_fifo;
  logic [MPS_W-1:0] resp_maxpkt;

  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  usb_ep_responder #(.NUM_EP(NUM_EP), .EP_W(EP_W), .FIFO_W(FIFO_W), .MPS_W(MPS_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_dir_in(cfg_dir_in), .cfg_ep(cfg_ep), .cfg_enable(cfg_enable),
    .cfg_active(cfg_active), .cfg_type(cfg_type), .cfg_stall(cfg_stall), .cfg_nak(cfg_nak),
    .cfg_toggle(cfg_toggle), .cfg_odd(cfg_odd), .cfg_snoop(cfg_snoop), .cfg_fifo(cfg_fifo),
    .cfg_maxpkt(cfg_maxpkt), .tok_valid(tok_valid), .tok_dir_in(tok_dir_in), .tok_ep(tok_ep),
    .fifo_ready(fifo_ready), .crc_ok(crc_ok), .rx_pid1(rx_pid1), .frame_odd(frame_odd),
    .host_ack(host_ack), .host_ack_ep(host_ack_ep), .resp_valid(resp_valid),
    .resp_code(resp_code), .resp_keep(resp_keep), .resp_fifo(resp_fifo),
    .resp_maxpkt(resp_maxpkt)
  );

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FIFO/handshake FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(logic din, int ep, logic en, logic act, logic [1:0] typ, logic st,
                     logic nk, logic tg, logic od, logic sn, int ff, int mp);
    @(negedge clk);
    cfg_we = 1; cfg_dir_in = din; cfg_ep = EP_W'(ep); cfg_enable = en; cfg_active = act;
    cfg_type = typ; cfg_stall = st; cfg_nak = nk; cfg_toggle = tg; cfg_odd = od;
    cfg_snoop = sn; cfg_fifo = FIFO_W'(ff); cfg_maxpkt = MPS_W'(mp);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Token presented for one cycle; the registered response is sampled at the next falling edge.
  task automatic tok(string req, logic din, int ep, logic fr, logic crc, logic pid, logic odd,
                     logic [2:0] exp_code, logic exp_keep);
    @(negedge clk);
    tok_valid = 1; tok_dir_in = din; tok_ep = EP_W'(ep); fifo_ready = fr; crc_ok = crc;
    rx_pid1 = pid; frame_odd = odd;
    @(negedge clk);
    tok_valid = 0;
    chk({req, " valid"}, int'(resp_valid), 1);
    chk({req, " code"}, int'(resp_code), int'(exp_code));
    chk({req, " keep"}, int'(resp_keep), int'(exp_keep));
  endtask

  task automatic ack(int ep);
    @(negedge clk);
    host_ack = 1; host_ack_ep = EP_W'(ep);
    @(negedge clk);
    host_ack = 0;
  endtask

  task automatic t_reset;
    chk("R10 reset valid", int'(resp_valid), 0);
    chk("R10 reset code", int'(resp_code), 0);
    chk("R10 reset keep", int'(resp_keep), 0);
    tok("R1 unprogrammed ep0", 0, 0, 1, 1, 0, 0, C_NONE, 0);
    @(negedge clk);
    chk("R10 idle after token", int'(resp_valid), 0);
  endtask

  task automatic t_inactive;
    cfg(0, 1, 1, 0, T_BULK, 0, 0, 0, 0, 0, 0, 0);
    tok("R1 enabled not active", 0, 1, 1, 1, 0, 0, C_NONE, 0);
    cfg(0, 1, 0, 1, T_BULK, 0, 0, 0, 0, 0, 0, 0);
    tok("R1 active not enabled", 0, 1, 1, 1, 0, 0, C_NONE, 0);
    cfg(0, 1, 1, 1, T_BULK, 0, 0, 0, 0, 0, 0, 0);
    tok("R1 toggle untouched", 0, 1, 1, 1, 0, 0, C_ACK, 1);
  endtask

  task automatic t_stall_nak;
    cfg(0, 1, 1, 1, T_BULK, 1, 1, 0, 0, 0, 0, 0);
    tok("R2 OUT stall fifo busy", 0, 1, 0, 1, 0, 0, C_STALL, 0);
    cfg(1, 2, 1, 1, T_INTR, 1, 0, 0, 0, 0, 1, 8);
    tok("R2 IN stall", 1, 2, 1, 1, 0, 0, C_STALL, 0);
    cfg(0, 1, 1, 1, T_BULK, 0, 1, 0, 0, 0, 0, 0);
    tok("R3 forced NAK fifo ready", 0, 1, 1, 1, 0, 0, C_NAK, 0);
    cfg(0, 1, 1, 1, T_BULK, 0, 0, 0, 0, 0, 0, 0);
    tok("R4 fifo not ready", 0, 1, 0, 1, 0, 0, C_NAK, 0);
    cfg(1, 2, 1, 1, T_BULK, 0, 0, 0, 0, 0, 1, 8);
    tok("R4 IN fifo empty", 1, 2, 0, 1, 0, 0, C_NAK, 0);
  endtask

  task automatic t_out_toggle;
    cfg(0, 1, 1, 1, T_BULK, 0, 0, 0, 0, 0, 0, 0);
    tok("R5 DATA0 accepted", 0, 1, 1, 1, 0, 0, C_ACK, 1);
    tok("R5 DATA1 accepted", 0, 1, 1, 1, 1, 0, C_ACK, 1);
    tok("R6 repeat DATA1 discarded", 0, 1, 1, 1, 1, 0, C_ACK, 0);
    tok("R6 toggle held, DATA0 accepted", 0, 1, 1, 1, 0, 0, C_ACK, 1);
    cfg(0, 1, 1, 1, T_INTR, 0, 0, 1, 0, 0, 0, 0);
    tok("R11 loaded toggle DATA1", 0, 1, 1, 1, 1, 0, C_ACK, 1);
  endtask

  task automatic t_crc;
    cfg(0, 1, 1, 1, T_BULK, 0, 0, 0, 0, 0, 0, 0);
    tok("R7 bad CRC silent", 0, 1, 1, 0, 0, 0, C_NONE, 0);
    tok("R7 toggle kept after bad CRC", 0, 1, 1, 1, 0, 0, C_ACK, 1);
    cfg(0, 1, 1, 1, T_BULK, 0, 0, 0, 0, 1, 0, 0);
    tok("R7 snoop accepts bad CRC", 0, 1, 1, 0, 0, 0, C_ACK, 1);
    tok("R7 snoop advanced toggle", 0, 1, 1, 0, 1, 0, C_ACK, 1);
  endtask

  task automatic t_in_toggle;
    cfg(1, 2, 1, 1, T_BULK, 0, 0, 0, 0, 0, 5, 64);
    tok("R8 first DATA0", 1, 2, 1, 1, 0, 0, C_D0, 0);
    chk("R8 fifo number", int'(resp_fifo), 5);
    chk("R8 packet size", int'(resp_maxpkt), 64);
    tok("R8 retry without ack", 1, 2, 1, 1, 0, 0, C_D0, 0);
    ack(2);
    tok("R8 after ack DATA1", 1, 2, 1, 1, 0, 0, C_D1, 0);
    ack(3);
    tok("R8 ack to other ep", 1, 2, 1, 1, 0, 0, C_D1, 0);
    ack(2);
    ack(2);
    tok("R8 double ack flips once", 1, 2, 1, 1, 0, 0, C_D0, 0);
  endtask

  task automatic t_iso;
    cfg(0, 3, 1, 1, T_ISO, 0, 0, 0, 1, 0, 0, 0);
    tok("R9 iso OUT odd frame kept", 0, 3, 1, 1, 1, 1, C_NONE, 1);
    tok("R9 iso OUT even frame dropped", 0, 3, 1, 1, 0, 0, C_NONE, 0);
    tok("R9 iso OUT fifo busy no NAK", 0, 3, 0, 1, 0, 1, C_NONE, 0);
    tok("R9 iso OUT toggle ignored", 0, 3, 1, 1, 0, 1, C_NONE, 1);
    cfg(1, 3, 1, 1, T_ISO, 0, 0, 0, 0, 0, 2, 1023);
    tok("R9 iso IN even frame", 1, 3, 1, 1, 0, 0, C_D0, 0);
    tok("R9 iso IN odd frame silent", 1, 3, 1, 1, 0, 1, C_NONE, 0);
    ack(3);
    tok("R9 iso IN ack no toggle", 1, 3, 1, 1, 0, 0, C_D0, 0);
    cfg(1, 3, 1, 1, T_ISO, 1, 0, 0, 0, 0, 2, 1023);
    tok("R9 iso stall no handshake", 1, 3, 1, 1, 0, 0, C_NONE, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_inactive();
    t_stall_nak();
    t_out_toggle();
    t_crc();
    t_in_toggle();
    t_iso();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule